// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider

This block performs unsigned division of a double-width dividend by a single-width divisor over several clock cycles. The caller presents the upper and lower halves of the dividend together with the divisor and pulses `start`. The unit then develops one quotient bit per cycle, most significant bit first. On each step the double-width partial remainder moves left by one place, and the divisor is subtracted from the upper half whenever the new quotient bit is 1.

The quotient bits enter the low end of the lower half as the dividend bits leave its top, so no separate quotient register is needed. When the run completes, the upper half holds the remainder and the lower half holds the quotient.

Before any iteration the unit checks for two cases in which the quotient cannot fit in `WIDTH` bits: a zero divisor, or an upper half that already equals or exceeds the divisor. In either case it raises `error` and finishes at once, without iterating.

Top module: `shift_sub_divider`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0.
- R2: For a nonzero divisor d and an upper half h with h < d, the run ends with `quotient` equal to floor((h·2^WIDTH + l)/d) and `remainder` equal to (h·2^WIDTH + l) mod d, where l is the lower half.
- R3: On every successful completion, `remainder` is less than the divisor.
- R4: A start accepted at clock edge E0 raises `done` in the cycle after edge E0+WIDTH, so the first sampling point with `done`=1 comes WIDTH+1 edges after the start is raised.
- R5: `done` is high for exactly one cycle. `busy` is high during the iterations, and `busy` and `done` are never high together.
- R6: A start with a divisor of 0 raises `done` and `error` in the cycle after the start edge, and `busy` stays 0.
- R7: A start whose upper half is equal to or greater than the divisor behaves the same way as R6.
- R8: `start` is ignored while `busy` is 1. A second start with other operands does not alter the running result.
- R9: `error` holds until the next accepted start. That start clears it when the new operands are valid.
- R10: The result stays correct when the left shift carries a 1 out of the upper half, for example with divisor 2^WIDTH−1 and upper half 2^WIDTH−2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend_hi | input | WIDTH | Upper half of the dividend |
| dividend_lo | input | WIDTH | Lower half of the dividend |
| divisor | input | WIDTH | Divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Divide by zero or quotient overflow |
| quotient | output | WIDTH | Quotient (the lower half register) |
| remainder | output | WIDTH | Remainder (the upper half register) |

## Verification
The fixed vectors are chosen to exercise different paths:
- Small operands with a zero upper half exercise only the comparison path.
- An all-ones lower half with divisor 1 produces a quotient of all ones.
- A divisor with its top bit set, paired with an upper half just below it, makes the carried-out bit force the subtraction. A design that compares only the shifted WIDTH bits gets this case wrong.
- A dividend smaller than the divisor gives a zero quotient and returns the whole dividend as the remainder.

Random operands with the upper half reduced below the divisor are checked against the product-plus-remainder identity and the remainder bound. Directed runs cover the two rejection cases, a start injected during a run, error clearing, and latency counted in edges.

// File: rtl/divider_pkg.sv
// Package: shared types for the shift-subtract divider.
// Assumes nothing beyond SystemVerilog 2017.
package divider_pkg;
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/div_step.sv
// Module: div_step
// One combinational iteration of restoring division. It shifts the
// double-width partial remainder left by one, decides the quotient bit, and
// subtracts the divisor from the upper half when that bit is 1.
// Assumes on entry that hi < div. The bit carried out of hi then means the
// shifted value exceeds div, so the modulo-2^WIDTH subtraction is exact.
module div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] hi,
    input  logic [WIDTH-1:0] lo,
    input  logic [WIDTH-1:0] div,
    output logic [WIDTH-1:0] hi_next,
    output logic [WIDTH-1:0] lo_next
);
    logic [WIDTH-1:0] shifted;
    logic             carry_out;
    logic             qbit;

    // Form the shifted remainder, pick the quotient bit, subtract when it is set.
    always_comb begin
        carry_out = hi[WIDTH-1];
        shifted   = {hi[WIDTH-2:0], lo[WIDTH-1]};
        qbit      = carry_out | (shifted >= div);
        hi_next   = qbit ? (shifted - div) : shifted;
        lo_next   = {lo[WIDTH-2:0], qbit};
    end
endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequencer for the divider. It accepts a start only while idle, ends a
// rejected start at once, and otherwise runs WIDTH iterations before
// pulsing done for one cycle.
// Assumes err_cond is valid in the same cycle as start.
module div_ctrl
    import divider_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic err_cond,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    div_state_t    state;
    logic [CW-1:0] count;

    // Decode strobes from the current state.
    always_comb begin
        load    = (state == DIV_IDLE) && start;
        step_en = (state == DIV_RUN);
        busy    = (state == DIV_RUN);
    end

    // Advance the state, the iteration count and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIV_IDLE;
            count <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                DIV_IDLE: begin
                    if (start) begin
                        count <= '0;
                        if (err_cond) begin
                            done  <= 1'b1;
                            error <= 1'b1;
                        end else begin
                            error <= 1'b0;
                            state <= DIV_RUN;
                        end
                    end
                end
                default: begin
                    if (count == LAST) begin
                        state <= DIV_IDLE;
                        done  <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_error_no_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && err_cond) |=> (done && error && !busy));
    assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && count == LAST) |=> done);
endmodule

// File: rtl/div_datapath.sv
// Module: div_datapath
// Holds the upper half, the lower half and the divisor registers. It loads
// them on an accepted start and applies one div_step per enabled cycle. It
// also flags the operand cases whose quotient cannot fit in WIDTH bits.
// Assumes load and step_en are never high together.
module div_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic [WIDTH-1:0] hi_in,
    input  logic [WIDTH-1:0] lo_in,
    input  logic [WIDTH-1:0] div_in,
    output logic             err_cond,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q,
    output logic [WIDTH-1:0] div_q
);
    logic [WIDTH-1:0] hi_next;
    logic [WIDTH-1:0] lo_next;

    // Reject a zero divisor or an upper half that already reaches the divisor.
    always_comb err_cond = (div_in == '0) || (hi_in >= div_in);

    div_step #(.WIDTH(WIDTH)) u_step (
        .hi      (hi_q),
        .lo      (lo_q),
        .div     (div_q),
        .hi_next (hi_next),
        .lo_next (lo_next)
    );

    // Load the operands or apply one iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            div_q <= '0;
        end else if (load) begin
            hi_q  <= hi_in;
            lo_q  <= lo_in;
            div_q <= div_in;
        end else if (step_en) begin
            hi_q <= hi_next;
            lo_q <= lo_next;
        end
    end

    assert_partial_below_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (hi_q < div_q));
    assert_div_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> $stable(div_q));
endmodule

// File: rtl/shift_sub_divider.sv
// Module: shift_sub_divider
// Top of the sequential unsigned divider. It divides the dividend
// {dividend_hi, dividend_lo} by divisor in WIDTH cycles. The remainder ends
// in the upper half register and the quotient in the lower half register.
// Assumes WIDTH >= 2 and that operands are valid in the cycle start is high.
module shift_sub_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend_hi,
    input  logic [WIDTH-1:0] dividend_lo,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic             load;
    logic             step_en;
    logic             err_cond;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] div_q;

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .err_cond (err_cond),
        .load     (load),
        .step_en  (step_en),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

    div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_en  (step_en),
        .hi_in    (dividend_hi),
        .lo_in    (dividend_lo),
        .div_in   (divisor),
        .err_cond (err_cond),
        .hi_q     (hi_q),
        .lo_q     (lo_q),
        .div_q    (div_q)
    );

    // Expose the result registers.
    always_comb begin
        quotient  = lo_q;
        remainder = hi_q;
    end

    assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (remainder < div_q));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

// File: tb/sim_shift_sub_divider.sv
`timescale 1ns/1ps
module sim_shift_sub_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend_hi = '0;
    logic [W-1:0] dividend_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, error;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    shift_sub_divider #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .busy(busy), .done(done), .error(error),
        .quotient(quotient), .remainder(remainder)
    );

    // Fixed vectors: {upper half, lower half, divisor}.
    localparam logic [3*W-1:0] VEC [6] = '{
        {32'h0000_0000, 32'h0000_0064, 32'h0000_0007},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001},
        {32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h1234_5678, 32'h9ABC_DEF0, 32'h8765_4321},
        {32'h0000_0000, 32'h0000_0005, 32'h0000_0009},
        {32'h7FFF_FFFF, 32'h0000_0000, 32'h8000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Start a division and wait for done. An optional stray start is injected mid-run.
    task automatic run(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d,
                       input bit inject, output int cycles);
        @(negedge clk);
        dividend_hi = h; dividend_lo = l; divisor = d; start = 1'b1;
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start = 1'b0;
            if (inject && cycles == 5) begin
                dividend_hi = 32'h0; dividend_lo = 32'h3; divisor = 32'h2; start = 1'b1;
            end
            if (done || cycles > 200) break;
        end
        start = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [63:0] dvd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 error", 64'(error), 64'd0);

        // Table walk: R2, R4, R10
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] h, l, d;
            {h, l, d} = VEC[i];
            dvd = {h, l};
            run(h, l, d, 1'b0, cyc);
            chk("R2 quotient", 64'(quotient), dvd / 64'(d));
            chk("R2 remainder", 64'(remainder), dvd % 64'(d));
            chk("R4 latency", 64'(cyc), 64'(W + 1));
            chk("R3 error low", 64'(error), 64'd0);
            @(negedge clk);
            chk("R5 done one cycle", 64'(done), 64'd0);
        end

        // R6 zero divisor
        run(32'h0, 32'h55, 32'h0, 1'b0, cyc);
        chk("R6 latency", 64'(cyc), 64'd1);
        chk("R6 error", 64'(error), 64'd1);
        chk("R6 busy", 64'(busy), 64'd0);
        // R7 upper half equal to divisor
        run(32'h10, 32'h0, 32'h10, 1'b0, cyc);
        chk("R7 equal latency", 64'(cyc), 64'd1);
        chk("R7 equal error", 64'(error), 64'd1);
        // R7 upper half above divisor
        run(32'h20, 32'h1, 32'h10, 1'b0, cyc);
        chk("R7 above error", 64'(error), 64'd1);
        chk("R7 above busy", 64'(busy), 64'd0);
        // R9 error held while idle, cleared by a valid start
        @(negedge clk);
        chk("R9 error held", 64'(error), 64'd1);
        run(32'h0, 32'd1000, 32'd10, 1'b0, cyc);
        chk("R9 error cleared", 64'(error), 64'd0);
        chk("R9 quotient", 64'(quotient), 64'd100);

        // R8 start while busy is ignored
        run(32'h0000_0001, 32'h0000_0000, 32'h0000_0003, 1'b1, cyc);
        chk("R8 quotient", 64'(quotient), 64'h1_0000_0000 / 64'd3);
        chk("R8 remainder", 64'(remainder), 64'h1_0000_0000 % 64'd3);
        chk("R8 latency", 64'(cyc), 64'(W + 1));

        // Random operands: R2 identity and R3 bound
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] h, l, d;
            d = $urandom;
            if (n % 4 == 0) d = d >> (n % 31);
            if (d == 0) d = 1;
            h = $urandom % d;
            l = $urandom;
            dvd = {h, l};
            run(h, l, d, 1'b0, cyc);
            chk("R2 identity", 64'(quotient) * 64'(d) + 64'(remainder), dvd);
            chk("R3 bound", 64'(remainder < d), 64'd1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule